// File: doc/BRIEF.md
# Memory-Protection Entry Configuration Register

This block holds one word of physical-memory-protection entry settings. The word carries one 8-bit configuration byte per protection entry. With a 64-bit register width there are eight bytes. With a 32-bit width only the low four bytes exist. The core reaches the word through a CSR-style port made of a write strobe, a 12-bit CSR address, the current privilege level and write data. The block answers on a combinational read port.

Every write is filtered byte by byte, and all bytes are judged in parallel. A byte that fails any legality rule is thrown away whole, and that entry keeps its previous value. The other bytes in the same write are still accepted.

The stored fields are also presented as decoded per-entry outputs: lock, address-match mode and the three access permissions. A downstream region checker uses these outputs. A set lock means the entry's permissions also bind machine-mode accesses.

Top module: `pmp_cfg_csr`

## Requirements
- R1: After reset every entry byte reads as 0x00. That is mode OFF, unlocked, with no permissions.
- R2: A write hits the register only when the strobe is high, the address equals `CFG_ADDR` (default 0x3A4) and the privilege is machine mode (2'b11). An accepted byte becomes visible on the cycle after the strobe.
- R3: A strobe with any other address, or with a privilege other than 2'b11, leaves every stored byte unchanged.
- R4: While the stored lock bit (bit 7) of an entry is 1, writes leave that entry's whole byte unchanged. The lock bit stays set until the next reset.
- R5: A byte that has write permission (bit 1) set while read permission (bit 0) is clear is rejected whole, and the old byte is kept. Other bytes in the same write are unaffected.
- R6: When `GRAN` is 2 or more, a byte whose mode field (bits 4:3) equals 2 (four-byte region) is rejected whole. When `GRAN` is below 2, such a byte is accepted.
- R7: Bits 6:5 of each byte are always stored and read back as 0, whatever is written to them.
- R8: With `XLEN` = 32, the bytes in bits 63:32 ignore writes and read as 0.
- R9: For entry i, `ent_lock[i]` is bit 7, `ent_mode[2i+1:2i]` is bits 4:3 (0 OFF, 1 top-of-range, 2 four-byte, 3 power-of-two), `ent_x[i]` is bit 2, `ent_w[i]` is bit 1 and `ent_r[i]` is bit 0 of the stored byte.
- R10: `csr_rdata` carries the stored word while `csr_addr` equals `CFG_ADDR`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for both read and write |
| csr_priv | input | 2 | Privilege of the access; 2'b11 is machine mode |
| csr_wdata | input | 64 | Write data, one byte per entry |
| csr_rdata | output | 64 | Stored word when addressed, else 0 |
| ent_lock | output | 8 | Per-entry lock; also extends checks to machine mode |
| ent_mode | output | 16 | Per-entry address-match mode, 2 bits each |
| ent_x | output | 8 | Per-entry execute permission |
| ent_w | output | 8 | Per-entry write permission |
| ent_r | output | 8 | Per-entry read permission |

## Verification
Locking and ordinary legalization collide when a single write both sets an entry's lock bit and changes its permissions. The bench provokes this and expects the byte to be taken in full, because only the lock already stored can block a write. The write on the very next cycle must then bounce off that byte while the unlocked neighbours accept new values. One write also mixes a reserved read/write pairing, a four-byte mode and clean bytes. It is judged against two instances with different granularity and width, so rejection and acceptance are seen side by side in the same cycle.

// File: rtl/pmpcfg_pkg.sv
package pmpcfg_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amatch_e;

  // bit 7 lock, 6:5 spare, 4:3 match mode, 2 exec, 1 write, 0 read
  typedef struct packed {
    logic    lock;
    logic [1:0] spare;
    amatch_e mode;
    logic    x;
    logic    w;
    logic    r;
  } entcfg_t;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

endpackage

// File: rtl/pmpcfg_legalize.sv
module pmpcfg_legalize
  import pmpcfg_pkg::*;
#(
  parameter int GRAN = 0
) (
  input  logic    cur_lock,
  input  entcfg_t req,
  output logic    accept,
  output entcfg_t clean
);

  logic rw_bad;
  logic na4_bad;

  assign rw_bad = req.w & ~req.r;

  generate
    if (GRAN >= 2) begin : g_coarse
      assign na4_bad = (req.mode == AM_NA4);
    end else begin : g_fine
      assign na4_bad = 1'b0;
    end
  endgenerate

  always_comb begin
    accept      = ~cur_lock & ~rw_bad & ~na4_bad;
    clean       = req;
    clean.spare = 2'b00;
  end

endmodule

// File: rtl/pmpcfg_entry.sv
module pmpcfg_entry
  import pmpcfg_pkg::*;
#(
  parameter int GRAN   = 0,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output entcfg_t           q
);

  entcfg_t req;
  entcfg_t clean;
  logic    accept;

  assign req = entcfg_t'(wr_byte);

  pmpcfg_legalize #(.GRAN(GRAN)) u_legal (
    .cur_lock (q.lock),
    .req      (req),
    .accept   (accept),
    .clean    (clean)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en && accept) begin
      q <= clean;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    q.lock |=> $stable(q)); // R4

  AST_NO_RW_PAIR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && req.w && !req.r) |=> $stable(q)); // R5

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && req.spare != 2'b00) |=> (q.spare == 2'b00)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q)); // R3

  generate
    if (GRAN >= 2) begin : g_na4_chk
      AST_NO_NA4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req.mode == AM_NA4) |=> $stable(q)); // R6
    end
  endgenerate

endmodule

// File: rtl/pmp_cfg_csr.sv
module pmp_cfg_csr
  import pmpcfg_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter int              GRAN     = 0,
  parameter int              WORD_W   = 64,
  parameter int              ADDR_W   = 12,
  parameter logic [11:0]     CFG_ADDR = 12'h3A4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   csr_we,
  input  logic [ADDR_W-1:0]      csr_addr,
  input  logic [1:0]             csr_priv,
  input  logic [WORD_W-1:0]      csr_wdata,
  output logic [WORD_W-1:0]      csr_rdata,
  output logic [WORD_W/8-1:0]    ent_lock,
  output logic [2*WORD_W/8-1:0]  ent_mode,
  output logic [WORD_W/8-1:0]    ent_x,
  output logic [WORD_W/8-1:0]    ent_w,
  output logic [WORD_W/8-1:0]    ent_r
);

  localparam int BYTE_W = 8;
  localparam int SLOTS  = WORD_W / BYTE_W;
  localparam int LIVE   = XLEN / BYTE_W;

  logic              cfg_hit;
  logic              rd_hit;
  entcfg_t           slot_q [SLOTS];
  logic [WORD_W-1:0] cfg_word;

  assign cfg_hit = csr_we && (csr_addr == CFG_ADDR[ADDR_W-1:0]) && (csr_priv == PRIV_MACHINE);
  assign rd_hit  = (csr_addr == CFG_ADDR[ADDR_W-1:0]);

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < LIVE) begin : g_live
        pmpcfg_entry #(.GRAN(GRAN), .BYTE_W(BYTE_W)) u_entry (
          .clk     (clk),
          .rst     (rst),
          .wr_en   (cfg_hit),
          .wr_byte (csr_wdata[i*BYTE_W +: BYTE_W]),
          .q       (slot_q[i])
        );
      end else begin : g_dead
        assign slot_q[i] = '0;
      end

      assign cfg_word[i*BYTE_W +: BYTE_W] = slot_q[i];
      assign ent_lock[i]       = slot_q[i].lock;
      assign ent_mode[2*i +: 2] = slot_q[i].mode;
      assign ent_x[i]          = slot_q[i].x;
      assign ent_w[i]          = slot_q[i].w;
      assign ent_r[i]          = slot_q[i].r;
    end
  endgenerate

  assign csr_rdata = rd_hit ? cfg_word : '0;

  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !cfg_hit |=> $stable(cfg_word)); // R3

  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (rst)
    (ent_lock != '0) |=> ((ent_lock & $past(ent_lock)) == $past(ent_lock))); // R4

  AST_READ_GATED: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |-> (csr_rdata == '0)); // R10

  generate
    if (LIVE < SLOTS) begin : g_narrow_chk
      AST_UPPER_DEAD: assert property (@(posedge clk) disable iff (rst)
        cfg_hit |=> (cfg_word[WORD_W-1:LIVE*BYTE_W] == '0)); // R8
    end
  endgenerate

endmodule

// File: tb/pmp_cfg_csr_test.sv
module pmp_cfg_csr_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = 12'h3A4;
  logic [1:0]  csr_priv = 2'b11;
  logic [63:0] csr_wdata = '0;

  logic [63:0] rd_a, rd_b;
  logic [7:0]  lk_a, lk_b, x_a, x_b, w_a, w_b, r_a, r_b;
  logic [15:0] md_a, md_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cyc    = 0;

  always #2 clk = ~clk;

  pmp_cfg_csr #(.XLEN(64), .GRAN(0)) uut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr), .csr_priv(csr_priv),
    .csr_wdata(csr_wdata), .csr_rdata(rd_a), .ent_lock(lk_a), .ent_mode(md_a),
    .ent_x(x_a), .ent_w(w_a), .ent_r(r_a));

  pmp_cfg_csr #(.XLEN(32), .GRAN(2)) uut_narrow (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr), .csr_priv(csr_priv),
    .csr_wdata(csr_wdata), .csr_rdata(rd_b), .ent_lock(lk_b), .ent_mode(md_b),
    .ent_x(x_b), .ent_w(w_b), .ent_r(r_b));

  // behavioural reference: one byte array per instance
  logic [7:0] ma [8];
  logic [7:0] mb [8];

  function automatic logic [7:0] ref_next(logic [7:0] old, logic [7:0] d, int gran, int live, int idx);
    if (idx >= live) return 8'h00;
    if (old[7]) return old;
    if (d[1] && !d[0]) return old;
    if (gran >= 2 && d[4:3] == 2'd2) return old;
    return d & 8'h9F;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (rst) begin
        ma[i] <= 8'h00;
        mb[i] <= 8'h00;
      end else if (csr_we && csr_addr == 12'h3A4 && csr_priv == 2'b11) begin
        ma[i] <= ref_next(ma[i], csr_wdata[i*8 +: 8], 0, 8, i);
        mb[i] <= ref_next(mb[i], csr_wdata[i*8 +: 8], 2, 4, i);
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_inst(string nm, logic [7:0] m [8], logic [63:0] rd, logic [7:0] lk,
                          logic [15:0] md, logic [7:0] xx, logic [7:0] ww, logic [7:0] rr);
    logic [63:0] word;
    logic [7:0]  el, ex, ew, er;
    logic [15:0] em;
    for (int i = 0; i < 8; i++) begin
      word[i*8 +: 8] = m[i];
      el[i] = m[i][7];
      ex[i] = m[i][2];
      ew[i] = m[i][1];
      er[i] = m[i][0];
      em[2*i +: 2] = m[i][4:3];
    end
    chk({"R10 rdata ", nm}, rd, (csr_addr == 12'h3A4) ? word : 64'h0);
    chk({"R9 decode ", nm}, {lk, xx, ww, rr, md}, {el, ex, ew, er, em});
  endtask

  // per-cycle model comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst && cyc > 2 && !done) begin
      cmp_inst("wide", ma, rd_a, lk_a, md_a, x_a, w_a, r_a);
      cmp_inst("narrow", mb, rd_b, lk_b, md_b, x_b, w_b, r_b);
    end
  end

  task automatic wr(logic [11:0] a, logic [1:0] p, logic [63:0] d);
    @(posedge clk); #1;
    csr_we = 1'b1; csr_addr = a; csr_priv = p; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 1'b0; csr_addr = 12'h3A4; csr_priv = 2'b11;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1'b1;
    repeat (2) @(posedge clk);
    #1; rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset wide", rd_a, 64'h0);
    chk("R1 reset narrow", rd_b, 64'h0);

    // R2 / R8: all-legal pattern
    wr(12'h3A4, 2'b11, 64'h1F0B_0907_0D05_0301);
    chk("R2 legal write wide", rd_a, 64'h1F0B_0907_0D05_0301);
    chk("R8 narrow upper zero", rd_b, 64'h0000_0000_0D05_0301);
    chk("R9 mode entry7", {62'h0, md_a[15:14]}, 64'd3);

    // R7: spare bits dropped, rest of byte kept
    wr(12'h3A4, 2'b11, 64'h1F0B_0907_0D05_0365);
    chk("R7 spare bits wide", {56'h0, rd_a[7:0]}, 64'h05);
    chk("R7 spare bits narrow", {56'h0, rd_b[7:0]}, 64'h05);

    // R5 / R6: reserved pairing in byte1, four-byte mode in byte2
    wr(12'h3A4, 2'b11, 64'h1F0B_0907_0D11_0205);
    chk("R5 rw pair kept old", {56'h0, rd_a[15:8]}, 64'h03);
    chk("R6 na4 fine accepted", {56'h0, rd_a[23:16]}, 64'h11);
    chk("R6 na4 coarse rejected", {56'h0, rd_b[23:16]}, 64'h05);
    chk("R5 neighbours accepted", rd_a, 64'h1F0B_0907_0D11_0305);

    // R3: wrong privilege, wrong address
    wr(12'h3A4, 2'b01, 64'h0);
    chk("R3 low privilege", rd_a, 64'h1F0B_0907_0D11_0305);
    wr(12'h3A0, 2'b11, 64'h0);
    chk("R3 other address", rd_a, 64'h1F0B_0907_0D11_0305);

    // R10: off-address read
    @(posedge clk); #1; csr_addr = 12'h3A5; @(negedge clk);
    chk("R10 off-address read", rd_a, 64'h0);
    @(posedge clk); #1; csr_addr = 12'h3A4; @(negedge clk);

    // R4: lock set together with new permissions, then back-to-back write
    @(posedge clk); #1;
    csr_we = 1'b1; csr_wdata = 64'h1F0B_0907_8311_0305;
    @(posedge clk); #1;
    csr_wdata = 64'h0;
    @(posedge clk); #1;
    csr_we = 1'b0;
    @(negedge clk);
    chk("R4 locked byte kept wide", rd_a, 64'h0000_0000_8300_0000);
    chk("R4 locked byte kept narrow", rd_b, 64'h0000_0000_8300_0000);
    chk("R9 lock flag", {56'h0, lk_a}, 64'h08);
    wr(12'h3A4, 2'b11, 64'h0000_0000_0F00_0000);
    chk("R4 lock still holds", rd_a, 64'h0000_0000_8300_0000);

    // R1 / R4: reset releases the lock
    do_reset();
    chk("R1 reset clears lock", rd_a, 64'h0);
    wr(12'h3A4, 2'b11, 64'h0000_0000_0F00_0000);
    chk("R4 unlocked after reset", rd_a, 64'h0000_0000_0F00_0000);
    chk("R8 upper ignored narrow", rd_b, 64'h0000_0000_0F00_0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule